// File: doc/BRIEF.md
# Tower Energy Latch with Channel Masking

The block keeps one 10-bit energy for each of six calorimeter towers in two channels, electromagnetic (EM) and hadronic (HAD). That makes twelve energy registers. It has two modes. In run mode the registers follow the live tower inputs on every clock edge. In test mode a host loads them, one tower pair per write, through a 20-bit write word and one write strobe per pair and channel.

Every channel has a mask bit. A masked channel gives zero on all of its derived outputs. Two views are derived from each latched energy. The first is an 8-bit reduced energy per channel, taken as either the low or the middle eight bits. The second is a 3-bit field per tower, taken from the HAD energy at one of two offsets. A read select puts one stored tower pair on a 32-bit readback word. Reads work in both modes.

Top module: `tower_energy_latch`

## Requirements
- R1: A synchronous active-high `rst` clears all twelve energy registers to zero. While `rst` is high, `rd_data` reads zero for every value of `rd_sel`.
- R2: In test mode (`run_en` = 0), `em_wr[p]` high at a clock edge loads `host_wdata[9:0]` into EM tower 2p and `host_wdata[19:10]` into EM tower 2p+1. `had_wr[p]` loads the HAD towers in the same way. Any combination of the six strobes may be high in the same cycle.
- R3: In test mode, a register whose strobe is low keeps its value. The live inputs have no effect in test mode.
- R4: In run mode (`run_en` = 1), every register captures its live input on each clock edge. Tower i comes from `live_em[10i+9:10i]` and `live_had[10i+9:10i]`.
- R5: In run mode, all six write strobes are ignored. The registers hold the live values only.
- R6: `em_mask[i]` or `had_mask[i]` high forces that tower's channel to zero on `em_e8` and `had_e8`. `had_mask[i]` also forces `had_fld` for tower i to zero. Masks do not affect the stored values or `rd_data`.
- R7: Tower i's reduced energy is at `em_e8[8i+7:8i]` and `had_e8[8i+7:8i]`. It is bits 7:0 of the stored energy when `gran_sel` = 0 and bits 8:1 when `gran_sel` = 1.
- R8: `had_fld[3i+2:3i]` is bits 2:0 of HAD tower i's energy when `fld_sel` = 0 and bits 3:1 when `fld_sel` = 1.
- R9: `rd_sel` values 0 to 2 select EM pair p = `rd_sel`, values 3 to 5 select HAD pair p = `rd_sel`-3, and values 6 and 7 return zero. The word is {12'b0, tower 2p+1, tower 2p}, unmasked, and can be read in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | 1 = run mode (live capture), 0 = test mode |
| host_wdata | input | 20 | Host write word holding one tower pair |
| em_wr | input | 3 | EM pair write strobes |
| had_wr | input | 3 | HAD pair write strobes |
| live_em | input | 60 | Live EM energies, 10 bits per tower |
| live_had | input | 60 | Live HAD energies, 10 bits per tower |
| em_mask | input | 6 | EM channel masks |
| had_mask | input | 6 | HAD channel masks |
| gran_sel | input | 1 | Reduced energy view: 0 = bits 7:0, 1 = bits 8:1 |
| fld_sel | input | 1 | HAD field view: 0 = bits 2:0, 1 = bits 3:1 |
| rd_sel | input | 3 | Readback pair select |
| rd_data | output | 32 | Readback word |
| em_e8 | output | 48 | Masked reduced EM energies |
| had_e8 | output | 48 | Masked reduced HAD energies |
| had_fld | output | 18 | Masked 3-bit HAD fields |

## Verification
A host write strobe can arrive in the same cycle that run mode is active. The bench provokes this by driving random strobes and write words while `run_en` is high. The registers must then equal the live inputs and must not take the host word. A read of a pair can also fall in the same cycle as a write to that pair, or while masks change. The behavioural reference model is compared on every cycle: the readback must show the value that was stored before the edge, and the mask must change only the derived views.

// File: rtl/tower_energy_latch.sv
module tower_energy_latch #(
  parameter int NPAIR = 3,
  parameter int EW    = 10,
  parameter int RW    = 8,
  parameter int FW    = 3,
  parameter int BUSW  = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      run_en,
  input  logic [2*EW-1:0]           host_wdata,
  input  logic [NPAIR-1:0]          em_wr,
  input  logic [NPAIR-1:0]          had_wr,
  input  logic [2*NPAIR*EW-1:0]     live_em,
  input  logic [2*NPAIR*EW-1:0]     live_had,
  input  logic [2*NPAIR-1:0]        em_mask,
  input  logic [2*NPAIR-1:0]        had_mask,
  input  logic                      gran_sel,
  input  logic                      fld_sel,
  input  logic [2:0]                rd_sel,
  output logic [BUSW-1:0]           rd_data,
  output logic [2*NPAIR*RW-1:0]     em_e8,
  output logic [2*NPAIR*RW-1:0]     had_e8,
  output logic [2*NPAIR*FW-1:0]     had_fld
);
  localparam int NT = 2 * NPAIR;
  localparam int PW = 2 * EW;

  logic [NT*EW-1:0] em_q, had_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      em_q  <= '0;
      had_q <= '0;
    end else if (run_en) begin
      em_q  <= live_em;
      had_q <= live_had;
    end else begin
      for (int p = 0; p < NPAIR; p++) begin
        if (em_wr[p])  em_q[p*PW +: PW]  <= host_wdata;
        if (had_wr[p]) had_q[p*PW +: PW] <= host_wdata;
      end
    end
  end

  for (genvar i = 0; i < NT; i++) begin : g_tow
    logic [EW-1:0] e, h;
    assign e = em_q[i*EW +: EW];
    assign h = had_q[i*EW +: EW];
    assign em_e8[i*RW +: RW]   = em_mask[i]  ? '0 : (gran_sel ? e[RW:1] : e[RW-1:0]);
    assign had_e8[i*RW +: RW]  = had_mask[i] ? '0 : (gran_sel ? h[RW:1] : h[RW-1:0]);
    assign had_fld[i*FW +: FW] = had_mask[i] ? '0 : (fld_sel ? h[FW:1] : h[FW-1:0]);
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_sel) < NPAIR)
      rd_data[PW-1:0] = em_q[int'(rd_sel)*PW +: PW];
    else if (int'(rd_sel) < 2*NPAIR)
      rd_data[PW-1:0] = had_q[(int'(rd_sel)-NPAIR)*PW +: PW];
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (em_q == '0 && had_q == '0));

  p_run_capture_r4: assert property (@(posedge clk) disable iff (rst)
    run_en |=> (em_q == $past(live_em) && had_q == $past(live_had)));

  p_test_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!run_en && em_wr == '0 && had_wr == '0) |=> ($stable(em_q) && $stable(had_q)));

  for (genvar p = 0; p < NPAIR; p++) begin : g_chk
    p_em_write_r2: assert property (@(posedge clk) disable iff (rst)
      (!run_en && em_wr[p]) |=> em_q[p*PW +: PW] == $past(host_wdata));
    p_had_write_r2: assert property (@(posedge clk) disable iff (rst)
      (!run_en && had_wr[p]) |=> had_q[p*PW +: PW] == $past(host_wdata));
  end
endmodule

// File: tb/sim_tower_energy_latch.sv
module sim_tower_energy_latch;
  logic clk = 0, rst = 1, run_en = 0, gran_sel = 0, fld_sel = 0;
  logic [19:0] host_wdata = '0;
  logic [2:0]  em_wr = '0, had_wr = '0, rd_sel = '0;
  logic [59:0] live_em = '0, live_had = '0;
  logic [5:0]  em_mask = '0, had_mask = '0;
  logic [31:0] rd_data;
  logic [47:0] em_e8, had_e8;
  logic [17:0] had_fld;
  int checks = 0, errors = 0;
  int ref_em [6];
  int ref_had [6];

  always #5 clk = ~clk;

  tower_energy_latch u0 (.clk(clk), .rst(rst), .run_en(run_en), .host_wdata(host_wdata),
    .em_wr(em_wr), .had_wr(had_wr), .live_em(live_em), .live_had(live_had),
    .em_mask(em_mask), .had_mask(had_mask), .gran_sel(gran_sel), .fld_sel(fld_sel),
    .rd_sel(rd_sel), .rd_data(rd_data), .em_e8(em_e8), .had_e8(had_e8), .had_fld(had_fld));

  always @(posedge clk) begin
    for (int i = 0; i < 6; i++) begin
      if (rst) begin
        ref_em[i] = 0; ref_had[i] = 0;
      end else if (run_en) begin
        ref_em[i]  = int'(live_em[i*10 +: 10]);
        ref_had[i] = int'(live_had[i*10 +: 10]);
      end else begin
        if (em_wr[i/2])  ref_em[i]  = int'(host_wdata[(i%2)*10 +: 10]);
        if (had_wr[i/2]) ref_had[i] = int'(host_wdata[(i%2)*10 +: 10]);
      end
    end
  end

  function automatic logic [47:0] exp_e8(bit had);
    logic [47:0] v = '0;
    for (int i = 0; i < 6; i++) begin
      int e = had ? ref_had[i] : ref_em[i];
      bit m = had ? had_mask[i] : em_mask[i];
      if (!m) v[i*8 +: 8] = gran_sel ? 8'((e >> 1) & 255) : 8'(e & 255);
    end
    return v;
  endfunction

  function automatic logic [17:0] exp_fld();
    logic [17:0] v = '0;
    for (int i = 0; i < 6; i++)
      if (!had_mask[i]) v[i*3 +: 3] = fld_sel ? 3'((ref_had[i] >> 1) & 7) : 3'(ref_had[i] & 7);
    return v;
  endfunction

  function automatic logic [31:0] exp_rd();
    int s = int'(rd_sel);
    if (s < 3) return 32'(ref_em[2*s+1] * 1024 + ref_em[2*s]);
    if (s < 6) return 32'(ref_had[2*(s-3)+1] * 1024 + ref_had[2*(s-3)]);
    return 32'd0;
  endfunction

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic go(string tag);
    #1;
    cmp(tag, "rd_data", 64'(rd_data), 64'(exp_rd()));
    cmp(tag, "em_e8",   64'(em_e8),   64'(exp_e8(0)));
    cmp(tag, "had_e8",  64'(had_e8),  64'(exp_e8(1)));
    cmp(tag, "had_fld", 64'(had_fld), 64'(exp_fld()));
  endtask

  task automatic rnd_bus(bit strobes);
    host_wdata = 20'($urandom);
    live_em  = {28'($urandom), 32'($urandom)};
    live_had = {28'($urandom), 32'($urandom)};
    em_wr  = strobes ? 3'($urandom) : 3'd0;
    had_wr = strobes ? 3'($urandom) : 3'd0;
    rd_sel = 3'($urandom);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset clears, readback zero for every select
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); rnd_bus(1); run_en = k[0]; rd_sel = 3'(k); go("R1");
    end
    @(negedge clk); rst = 0; run_en = 0; em_wr = '0; had_wr = '0; go("R1");
    // R2: test-mode pair writes, any strobe combination
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); rnd_bus(1); go("R2");
    end
    // R3: no strobes, live inputs toggling
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); rnd_bus(0); go("R3");
    end
    // R4: run-mode live capture
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); run_en = 1; rnd_bus(0); go("R4");
    end
    // R5: run mode with strobes active in the same cycle
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); run_en = 1; rnd_bus(1); em_wr = 3'b111; had_wr = 3'(k); go("R5");
    end
    // R3: back in test mode, last live capture is retained
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); run_en = 0; rnd_bus(0); go("R3");
    end
    // R6: mask patterns, including all-set and all-clear
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); rnd_bus(1);
      em_mask  = (k < 2) ? {6{k[0]}} : 6'($urandom);
      had_mask = (k < 2) ? {6{k[0]}} : 6'($urandom);
      go("R6");
    end
    em_mask = '0; had_mask = '0;
    // R7: granularity view
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); rnd_bus(1); gran_sel = k[0]; run_en = k[3]; go("R7");
    end
    // R8: HAD field view
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); rnd_bus(1); fld_sel = k[0]; had_mask = 6'($urandom); go("R8");
    end
    had_mask = '0;
    // R9: readback sweep in both modes
    for (int k = 0; k < 32; k++) begin
      @(negedge clk); rnd_bus(k < 16); run_en = k[4]; rd_sel = 3'(k); go("R9");
    end
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule